// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core

This block is a 32-bit processor that fetches, decodes, executes and retires one instruction on every rising clock edge. It implements eight instructions: four register-to-register arithmetic and logic operations (add, subtract, bitwise AND, bitwise OR), a signed set-less-than, a word load, a word store and a branch taken when two registers are equal. Program and data live in two separate internal word arrays. The program array is never written while the core runs. The data array is written by stores.

A combinational decoder reads the opcode, function and shift-amount fields and sets the datapath selects. These are the destination-register choice, the second ALU operand choice, the write-back source, the memory enables and the branch enable. The ALU's zero flag, after a subtraction, decides whether a branch is taken. The core's architectural effects are shown on its ports every cycle: the current program counter, the register write-back (enable, index, value) and the memory store (enable, byte address, value). An environment preloads both arrays before it releases reset, then watches these ports.

Top module: `sc_core`

## Requirements
- R1: A synchronous, active-high reset sets the program counter to 0. In the first cycle after reset is released, `pc_o` reads 0.
- R2: For every instruction except a taken branch, the program counter advances by 4 on each rising edge.
- R3: An instruction with opcode 000000, shift amount 0 and function code 100000, 100010, 100100 or 100101 writes rs+rt, rs−rt, rs AND rt or rs OR rt into register rd. The fields are op [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6] and function [5:0].
- R4: Opcode 000000 with function code 101010 writes 1 to rd when rs is less than rt as two's-complement values, and writes 0 otherwise.
- R5: Opcode 000100 subtracts rt from rs. When the result is zero, the next PC is PC+4 plus the sign-extended 16-bit immediate [15:0] shifted left by two. Otherwise the next PC is PC+4. The branch writes neither a register nor memory.
- R6: Opcode 100011 loads the data word at byte address rs + sign-extended immediate into register rt. Negative offsets are allowed. The word index is taken from address bits [log2(depth)+1:2].
- R7: Opcode 101011 stores register rt at byte address rs + sign-extended immediate, and does not write the register file in the same cycle.
- R8: Register 0 always reads as zero. A write aimed at it has no effect.
- R9: An unknown opcode, an unknown function code, or an arithmetic instruction with a non-zero shift amount executes as a no-op. It writes neither a register nor memory, and the PC advances by 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the program counter |
| pc_o | output | 32 | Byte address of the instruction executing this cycle |
| wb_en_o | output | 1 | Register write-back enable for this instruction |
| wb_idx_o | output | 5 | Destination register index of the write-back |
| wb_data_o | output | 32 | Value being written back |
| st_en_o | output | 1 | Data memory store enable for this instruction |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word being stored |

## Verification
The in-RTL assertions assume that reset is asserted at the first clock edge. They also assume that the program and data arrays are loaded before reset is released, so that every fetched word is defined. The bench writes both arrays at time zero, holds reset for three edges, and only reads registers that the program has already written, or register 0. Branch offsets in the program keep every fetch inside the program array, so the assertion on PC stepping never sees an undefined instruction.

// File: rtl/sc_pkg.sv
package sc_pkg;

   localparam int unsigned XLEN    = 32;
   localparam int unsigned RIDX_W  = 5;

   localparam logic [5:0] OPC_ALU   = 6'b000000;
   localparam logic [5:0] OPC_LOAD  = 6'b100011;
   localparam logic [5:0] OPC_STORE = 6'b101011;
   localparam logic [5:0] OPC_BREQ  = 6'b000100;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_fn_e;

   typedef struct packed {
      logic    dst_is_rd;
      logic    reg_we;
      logic    opb_imm;
      alu_fn_e alu_fn;
      logic    mem_re;
      logic    mem_we;
      logic    wb_from_mem;
      logic    is_branch;
   } ctl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
   import sc_pkg::*;
(
   input  logic [XLEN-1:0] instr_i,
   output ctl_t            ctl_o
);

   logic [5:0] opc;
   logic [5:0] fn;
   logic [4:0] shamt;

   assign opc   = instr_i[31:26];
   assign fn    = instr_i[5:0];
   assign shamt = instr_i[10:6];

   always_comb begin
      ctl_o = '{dst_is_rd: 1'b0, reg_we: 1'b0, opb_imm: 1'b0, alu_fn: ALU_ADD,
                mem_re: 1'b0, mem_we: 1'b0, wb_from_mem: 1'b0, is_branch: 1'b0};
      unique case (opc)
         OPC_ALU: begin
            if (shamt == 5'd0) begin
               unique case (fn)
                  FN_ADD: begin ctl_o.alu_fn = ALU_ADD; ctl_o.reg_we = 1'b1; end
                  FN_SUB: begin ctl_o.alu_fn = ALU_SUB; ctl_o.reg_we = 1'b1; end
                  FN_AND: begin ctl_o.alu_fn = ALU_AND; ctl_o.reg_we = 1'b1; end
                  FN_OR:  begin ctl_o.alu_fn = ALU_OR;  ctl_o.reg_we = 1'b1; end
                  FN_SLT: begin ctl_o.alu_fn = ALU_SLT; ctl_o.reg_we = 1'b1; end
                  default: ctl_o.reg_we = 1'b0;
               endcase
               ctl_o.dst_is_rd = ctl_o.reg_we;
            end
         end
         OPC_LOAD: begin
            ctl_o.reg_we      = 1'b1;
            ctl_o.opb_imm     = 1'b1;
            ctl_o.mem_re      = 1'b1;
            ctl_o.wb_from_mem = 1'b1;
         end
         OPC_STORE: begin
            ctl_o.opb_imm = 1'b1;
            ctl_o.mem_we  = 1'b1;
         end
         OPC_BREQ: begin
            ctl_o.alu_fn    = ALU_SUB;
            ctl_o.is_branch = 1'b1;
         end
         default: ctl_o.reg_we = 1'b0;
      endcase
   end

endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int unsigned W = XLEN
) (
   input  logic [W-1:0] a_i,
   input  logic [W-1:0] b_i,
   input  alu_fn_e      fn_i,
   output logic [W-1:0] y_o,
   output logic         zero_o
);

   logic [W-1:0] diff;
   logic         lt_signed;

   generate
      if (W < 2) begin : g_bad_width
         $error("sc_alu: W must be at least 2");
      end
   endgenerate

   assign diff = a_i - b_i;
   // signed compare: overflow-aware sign of the difference
   assign lt_signed = (a_i[W-1] ^ b_i[W-1]) ? a_i[W-1] : diff[W-1];

   always_comb begin
      unique case (fn_i)
         ALU_AND: y_o = a_i & b_i;
         ALU_OR:  y_o = a_i | b_i;
         ALU_ADD: y_o = a_i + b_i;
         ALU_SUB: y_o = diff;
         ALU_SLT: y_o = {{(W-1){1'b0}}, lt_signed};
         default: y_o = '0;
      endcase
   end

   assign zero_o = (y_o == '0);

   // R4
   always_comb begin
      if (fn_i == ALU_SLT) begin
         slt_range_chk: assert (y_o[W-1:1] == '0);
      end
   end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
   import sc_pkg::*;
#(
   parameter int unsigned W     = XLEN,
   parameter int unsigned NREGS = 32
) (
   input  logic                       clk,
   input  logic                       we_i,
   input  logic [$clog2(NREGS)-1:0]   wa_i,
   input  logic [W-1:0]               wd_i,
   input  logic [$clog2(NREGS)-1:0]   ra_a_i,
   input  logic [$clog2(NREGS)-1:0]   ra_b_i,
   output logic [W-1:0]               rd_a_o,
   output logic [W-1:0]               rd_b_o
);

   localparam int unsigned AW = $clog2(NREGS);

   logic [W-1:0] regs_q [NREGS];

   generate
      if (NREGS != (1 << RIDX_W)) begin : g_bad_depth
         $error("sc_regfile: NREGS must match the 5-bit register index");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (we_i && (wa_i != '0)) begin
         regs_q[wa_i] <= wd_i;
      end
   end

   assign rd_a_o = (ra_a_i == '0) ? '0 : regs_q[ra_a_i];
   assign rd_b_o = (ra_b_i == '0) ? '0 : regs_q[ra_b_i];

   logic [AW-1:0] unused_aw;
   assign unused_aw = '0;

endmodule

// File: rtl/sc_wordmem.sv
module sc_wordmem
   import sc_pkg::*;
#(
   parameter int unsigned W        = XLEN,
   parameter int unsigned WORDS    = 64,
   parameter bit          WRITABLE = 1'b1
) (
   input  logic                     clk,
   input  logic                     we_i,
   input  logic [$clog2(WORDS)-1:0] waddr_i,
   input  logic [W-1:0]             wdata_i,
   input  logic [$clog2(WORDS)-1:0] raddr_i,
   output logic [W-1:0]             rdata_o
);

   logic [W-1:0] mem_q [WORDS];

   generate
      if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
         $error("sc_wordmem: WORDS must be a power of two, at least 2");
      end
      if (WRITABLE) begin : g_rw
         always_ff @(posedge clk) begin
            if (we_i) begin
               mem_q[waddr_i] <= wdata_i;
            end
         end
      end else begin : g_ro
         logic unused_wr;
         assign unused_wr = ^{clk, we_i, waddr_i, wdata_i};
      end
   endgenerate

   assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int unsigned IMEM_WORDS = 64,
   parameter int unsigned DMEM_WORDS = 64,
   parameter int unsigned NREGS      = 32
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] pc_o,
   output logic        wb_en_o,
   output logic [4:0]  wb_idx_o,
   output logic [31:0] wb_data_o,
   output logic        st_en_o,
   output logic [31:0] st_addr_o,
   output logic [31:0] st_data_o
);

   localparam int unsigned IAW = $clog2(IMEM_WORDS);
   localparam int unsigned DAW = $clog2(DMEM_WORDS);

   generate
      if (XLEN != 32) begin : g_bad_xlen
         $error("sc_core: datapath must be 32 bits");
      end
      if (IAW + 2 > XLEN || DAW + 2 > XLEN) begin : g_bad_mem
         $error("sc_core: memory depth exceeds address space");
      end
   endgenerate

   logic [XLEN-1:0] pc_q, pc_plus4, br_tgt, pc_next;
   logic [XLEN-1:0] instr;
   ctl_t            ctl;
   logic [4:0]      rs_idx, rt_idx, rd_idx, dst_idx;
   logic [XLEN-1:0] rs_val, rt_val, imm_ext, opb, alu_y, ld_word, ld_val, wb_val;
   logic            alu_zero, br_take;

   // fetch
   sc_wordmem #(.W(XLEN), .WORDS(IMEM_WORDS), .WRITABLE(1'b0)) u_imem (
      .clk     (clk),
      .we_i    (1'b0),
      .waddr_i ('0),
      .wdata_i ('0),
      .raddr_i (pc_q[IAW+1:2]),
      .rdata_o (instr)
   );

   sc_decode u_dec (
      .instr_i (instr),
      .ctl_o   (ctl)
   );

   assign rs_idx  = instr[25:21];
   assign rt_idx  = instr[20:16];
   assign rd_idx  = instr[15:11];
   assign dst_idx = ctl.dst_is_rd ? rd_idx : rt_idx;
   assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

   sc_regfile #(.W(XLEN), .NREGS(NREGS)) u_rf (
      .clk    (clk),
      .we_i   (ctl.reg_we),
      .wa_i   (dst_idx),
      .wd_i   (wb_val),
      .ra_a_i (rs_idx),
      .ra_b_i (rt_idx),
      .rd_a_o (rs_val),
      .rd_b_o (rt_val)
   );

   assign opb = ctl.opb_imm ? imm_ext : rt_val;

   sc_alu #(.W(XLEN)) u_alu (
      .a_i    (rs_val),
      .b_i    (opb),
      .fn_i   (ctl.alu_fn),
      .y_o    (alu_y),
      .zero_o (alu_zero)
   );

   sc_wordmem #(.W(XLEN), .WORDS(DMEM_WORDS), .WRITABLE(1'b1)) u_dmem (
      .clk     (clk),
      .we_i    (ctl.mem_we),
      .waddr_i (alu_y[DAW+1:2]),
      .wdata_i (rt_val),
      .raddr_i (alu_y[DAW+1:2]),
      .rdata_o (ld_word)
   );

   assign ld_val = ctl.mem_re ? ld_word : '0;
   assign wb_val = ctl.wb_from_mem ? ld_val : alu_y;

   // next PC
   assign pc_plus4 = pc_q + 32'd4;
   assign br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
   assign br_take  = ctl.is_branch & alu_zero;
   assign pc_next  = br_take ? br_tgt : pc_plus4;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_q <= '0;
      end else begin
         pc_q <= pc_next;
      end
   end

   assign pc_o      = pc_q;
   assign wb_en_o   = ctl.reg_we;
   assign wb_idx_o  = dst_idx;
   assign wb_data_o = wb_val;
   assign st_en_o   = ctl.mem_we;
   assign st_addr_o = alu_y;
   assign st_data_o = rt_val;

   // ---------------- assertions ----------------
   logic past_ok_q;
   always_ff @(posedge clk) begin
      past_ok_q <= !rst;
   end

   // R1
   pc_reset_chk: assert property (@(posedge clk) rst |=> (pc_q == '0));

   // R2
   pc_step_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok_q && !$past(ctl.is_branch)) |-> (pc_q == $past(pc_q) + 32'd4));

   // R5
   br_fall_chk: assert property (@(posedge clk) disable iff (rst)
      (past_ok_q && $past(ctl.is_branch) && !$past(alu_zero))
         |-> (pc_q == $past(pc_q) + 32'd4));

   // R7
   st_no_wb_chk: assert property (@(posedge clk) disable iff (rst)
      st_en_o |-> !wb_en_o);

   // R8
   zero_src_chk: assert property (@(posedge clk) disable iff (rst)
      (rs_idx == 5'd0) |-> (rs_val == '0));

endmodule

// File: tb/sc_core_tb.sv
module sc_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] pc_o, wb_data_o, st_addr_o, st_data_o;
   logic [4:0]  wb_idx_o;
   logic        wb_en_o, st_en_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #4 clk = ~clk;

   sc_core u_dut (
      .clk       (clk),
      .rst       (rst),
      .pc_o      (pc_o),
      .wb_en_o   (wb_en_o),
      .wb_idx_o  (wb_idx_o),
      .wb_data_o (wb_data_o),
      .st_en_o   (st_en_o),
      .st_addr_o (st_addr_o),
      .st_data_o (st_data_o)
   );

   logic [31:0] prog [64];
   logic [31:0] mdat [64];
   logic [31:0] mreg [32];

   function automatic logic [31:0] rt_op(int rs, int rt, int rd, logic [5:0] fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction

   function automatic logic [31:0] i_op(logic [5:0] op, int rs, int rt, int imm);
      return {op, 5'(rs), 5'(rt), 16'(imm)};
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   initial begin
      #(8 * 5000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] mpc, ins, a, b, y, nxt;
      logic [31:0] e_wd, e_sa, e_sd;
      logic        e_we, e_st;
      logic [4:0]  e_idx;
      string       tag, pc_tag;

      for (int i = 0; i < 64; i++) begin
         prog[i] = 32'h0;
         mdat[i] = 32'h0;
      end
      for (int i = 0; i < 32; i++) mreg[i] = 32'h0;
      mdat[0] = 32'd5;
      mdat[1] = 32'hFFFF_FFFD;
      mdat[3] = 32'd16;

      prog[0]  = i_op(6'b100011, 0, 1, 0);       // lw r1,0(r0)
      prog[1]  = i_op(6'b100011, 0, 2, 4);       // lw r2,4(r0)
      prog[2]  = rt_op(1, 2, 3, 6'b100000);      // add
      prog[3]  = rt_op(1, 2, 4, 6'b100010);      // sub
      prog[4]  = rt_op(1, 2, 5, 6'b100100);      // and
      prog[5]  = rt_op(1, 2, 6, 6'b100101);      // or
      prog[6]  = rt_op(2, 1, 7, 6'b101010);      // slt -> 1
      prog[7]  = rt_op(1, 2, 8, 6'b101010);      // slt -> 0
      prog[8]  = rt_op(1, 1, 0, 6'b100000);      // write r0 (ignored)
      prog[9]  = i_op(6'b101011, 0, 3, 8);       // sw r3,8(r0)
      prog[10] = i_op(6'b100011, 0, 10, 12);     // lw r10,12(r0)
      prog[11] = i_op(6'b100011, 10, 9, -8);     // lw r9,-8(r10)
      prog[12] = i_op(6'b000100, 1, 2, 5);       // beq not taken
      prog[13] = i_op(6'b000100, 3, 9, 2);       // beq taken -> word 16
      prog[14] = rt_op(1, 1, 11, 6'b100000);     // skipped
      prog[15] = rt_op(1, 1, 11, 6'b100000);     // skipped
      prog[16] = 32'hFC00_0000;                  // unknown opcode
      prog[17] = rt_op(1, 2, 13, 6'b000111);     // unknown func
      prog[18] = {6'b0, 5'd1, 5'd1, 5'd14, 5'd3, 6'b100000}; // shamt!=0
      prog[19] = rt_op(0, 1, 12, 6'b100000);     // r12 = 0 + r1
      prog[20] = rt_op(0, 0, 13, 6'b100000);     // r13 = r0 + r0
      prog[21] = i_op(6'b101011, 0, 4, 20);      // sw r4,20(r0)
      prog[22] = i_op(6'b100011, 0, 15, 20);     // lw r15,20(r0)
      prog[23] = i_op(6'b000100, 0, 0, -1);      // spin

      for (int i = 0; i < 64; i++) begin
         u_dut.u_imem.mem_q[i] = prog[i];
         u_dut.u_dmem.mem_q[i] = mdat[i];
      end

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      mpc = 32'h0;
      pc_tag = "R1";

      for (int cyc = 0; cyc < 40; cyc++) begin
         ins   = prog[(mpc >> 2) & 63];
         a     = (ins[25:21] == 0) ? 32'h0 : mreg[ins[25:21]];
         b     = (ins[20:16] == 0) ? 32'h0 : mreg[ins[20:16]];
         e_we  = 1'b0; e_st = 1'b0; e_idx = 5'd0;
         e_wd  = 32'h0; e_sa = 32'h0; e_sd = 32'h0;
         nxt   = mpc + 4;
         tag   = "R9";
         y     = 32'h0;
         case (ins[31:26])
            6'b000000: begin
               if (ins[10:6] == 0) begin
                  e_idx = ins[15:11];
                  e_we  = 1'b1;
                  tag   = "R3";
                  case (ins[5:0])
                     6'b100000: e_wd = a + b;
                     6'b100010: e_wd = a - b;
                     6'b100100: e_wd = a & b;
                     6'b100101: e_wd = a | b;
                     6'b101010: begin
                        e_wd = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                        tag  = "R4";
                     end
                     default: begin e_we = 1'b0; tag = "R9"; end
                  endcase
                  if (e_we && (ins[25:21] == 0 || ins[20:16] == 0 || e_idx == 0))
                     tag = "R8";
               end
            end
            6'b100011: begin
               y     = a + {{16{ins[15]}}, ins[15:0]};
               e_we  = 1'b1;
               e_idx = ins[20:16];
               e_wd  = mdat[(y >> 2) & 63];
               tag   = "R6";
            end
            6'b101011: begin
               y    = a + {{16{ins[15]}}, ins[15:0]};
               e_st = 1'b1;
               e_sa = y;
               e_sd = b;
               tag  = "R7";
            end
            6'b000100: begin
               tag = "R5";
               if (a == b) nxt = mpc + 4 + ({{16{ins[15]}}, ins[15:0]} << 2);
            end
            default: tag = "R9";
         endcase

         chk(pc_tag, "pc", pc_o, mpc);
         chk(tag, "wb_en", {31'h0, wb_en_o}, {31'h0, e_we});
         chk(tag, "st_en", {31'h0, st_en_o}, {31'h0, e_st});
         if (e_we) begin
            chk(tag, "wb_idx", {27'h0, wb_idx_o}, {27'h0, e_idx});
            chk(tag, "wb_data", wb_data_o, e_wd);
         end
         if (e_st) begin
            chk(tag, "st_addr", st_addr_o, e_sa);
            chk(tag, "st_data", st_data_o, e_sd);
         end

         if (e_we && e_idx != 0) mreg[e_idx] = e_wd;
         if (e_st) mdat[(e_sa >> 2) & 63] = e_sd;
         pc_tag = (ins[31:26] == 6'b000100) ? "R5" : "R2";
         mpc = nxt;
         @(negedge clk);
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule